// File: doc/BRIEF.md
# Shrinking-Row Vector Address Generator

This block walks a two-level loop nest in which the inner trip count depends on the outer index, the access shape of triangular solvers and factorizations. Each outer step (a "row") covers a run of consecutive element addresses. The run is one decrement shorter than the row before it. The block hands out those addresses as vector beats of a fixed lane count. Each beat carries the lane-0 address, and lane k is implied at that address plus k. A per-lane enable field switches off the lanes that fall past the end of a row, so software never builds masks by hand.

A one-cycle start pulse captures six settings:
- a base address
- the number of rows
- the length of the first row
- the per-row length decrement
- a row stride
- a diagonal offset that is added per row

A decrement of zero turns the walk into an ordinary rectangular stream. Beats leave on a valid/ready handshake with two flags: one marks the last beat of each row and one marks the last beat of the whole stream. A single-cycle done pulse follows the final beat.

Top module: `isag_top`

## Requirements
- R1: While reset is held, and right after it, `beat_valid_o` and `done_o` are low.
- R2: Row i (counting from 0) holds `cfg_len_i - i*cfg_dec_i` elements. The first row whose length is zero or negative ends the stream: it and every later row produce no beats. At most `cfg_rows_i` rows are produced.
- R3: Row i starts at `cfg_base_i + i*(cfg_stride_i + cfg_diag_i)`, modulo 2^AW. Within a row, successive beats step the lane-0 address by VW.
- R4: `beat_mask_o` bit k, with lane 0 at bit 0, is 1 exactly when the element offset of lane k within the row is below the row length. Every beat except the last of its row has all VW bits set.
- R5: `beat_row_last_o` is 1 only on the final beat of each row. `beat_strm_last_o` is 1 only on the final beat of the stream, and that beat also carries `beat_row_last_o`.
- R6: With `cfg_dec_i` = 0, every row has the full length `cfg_len_i` and all `cfg_rows_i` rows are produced.
- R7: While `beat_valid_o` is high and `beat_ready_i` is low, the valid, address, mask and both flags stay unchanged into the next cycle. The address advances only when valid and ready are both high.
- R8: `done_o` is high for exactly one cycle. That cycle is the one after the beat with `beat_strm_last_o` is accepted. If the settings give no beats at all (zero rows or zero first length), it is instead the cycle after the start pulse, and no beat is offered.
- R9: A start pulse that arrives while a stream is being offered has no effect on the beats that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Captures the settings and begins a stream when idle |
| cfg_base_i | input | AW | Address of row 0, lane 0 |
| cfg_rows_i | input | LW | Outer trip count |
| cfg_len_i | input | LW | Element count of row 0 |
| cfg_dec_i | input | LW | Amount each row is shorter than the previous one |
| cfg_stride_i | input | AW | Address step between row starts |
| cfg_diag_i | input | AW | Extra per-row address step (diagonal shift) |
| beat_valid_o | output | 1 | A beat is offered |
| beat_ready_i | input | 1 | Consumer accepts the offered beat |
| beat_addr_o | output | AW | Lane-0 element address of the beat |
| beat_mask_o | output | VW | Lane enables, lane 0 at bit 0 |
| beat_row_last_o | output | 1 | Final beat of the current row |
| beat_strm_last_o | output | 1 | Final beat of the stream |
| done_o | output | 1 | One-cycle pulse after the stream ends |

## Verification
The main function is run over four groups of settings:
- Strictly shrinking triangles, with and without a diagonal shift. These separate the per-row length from the per-row start address.
- Zero-decrement rectangles. These show that the shrinking logic stays out of a plain stream.
- Decrements large enough that a row hits zero length before the row count runs out. These separate the two ways a stream can end.
- Lengths that are exact multiples of the lane count, next to lengths that are not. These separate full-width final beats from masked ones.

The handshake is tried with the consumer always ready and with periodic back-pressure, which shows whether beats hold still. One run injects a stray start mid-stream. Further runs cover empty settings, address wrap and reset in mid-stream.

// File: rtl/isag_pkg.sv
package isag_pkg;

    // Walk phase of the generator
    typedef enum logic [0:0] {
        PH_IDLE   = 1'b0,
        PH_STREAM = 1'b1
    } phase_e;

endpackage

// File: rtl/isag_beat_fmt.sv
// Turns the remaining element count of the current row into lane enables
// and the end-of-row flag.
module isag_beat_fmt #(
    parameter int VW = 4,
    parameter int LW = 12
) (
    input  logic [LW-1:0] rem_i,
    output logic [VW-1:0] mask_o,
    output logic          row_last_o
);
    localparam logic [LW-1:0] VW_L = LW'(VW);

    for (genvar k = 0; k < VW; k++) begin : g_lane
        assign mask_o[k] = (rem_i > LW'(k));
    end

    assign row_last_o = (rem_i <= VW_L);

endmodule

// File: rtl/isag_row_step.sv
// Computes the length and start address of the next row, and whether the
// current row is the last one holding any elements.
module isag_row_step #(
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic [LW-1:0] row_len_i,
    input  logic [LW-1:0] dec_i,
    input  logic [LW-1:0] row_idx_i,
    input  logic [LW-1:0] rows_i,
    input  logic [AW-1:0] row_addr_i,
    input  logic [AW-1:0] step_i,
    output logic [LW-1:0] next_len_o,
    output logic [AW-1:0] next_addr_o,
    output logic          final_row_o
);
    logic [LW:0] idx_plus;
    logic        next_empty;
    logic        out_of_rows;

    assign idx_plus    = {1'b0, row_idx_i} + {{LW{1'b0}}, 1'b1};
    assign out_of_rows = (idx_plus >= {1'b0, rows_i});
    // Lengths never grow, so an empty next row ends the walk for good
    assign next_empty  = (dec_i >= row_len_i);
    assign next_len_o  = row_len_i - dec_i;
    assign next_addr_o = row_addr_i + step_i;
    assign final_row_o = out_of_rows || next_empty;

endmodule

// File: rtl/isag_top.sv
module isag_top #(
    parameter int AW = 16,
    parameter int LW = 12,
    parameter int VW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] cfg_base_i,
    input  logic [LW-1:0] cfg_rows_i,
    input  logic [LW-1:0] cfg_len_i,
    input  logic [LW-1:0] cfg_dec_i,
    input  logic [AW-1:0] cfg_stride_i,
    input  logic [AW-1:0] cfg_diag_i,
    output logic          beat_valid_o,
    input  logic          beat_ready_i,
    output logic [AW-1:0] beat_addr_o,
    output logic [VW-1:0] beat_mask_o,
    output logic          beat_row_last_o,
    output logic          beat_strm_last_o,
    output logic          done_o
);
    import isag_pkg::*;

    localparam logic [AW-1:0] BEAT_STEP = AW'(VW);
    localparam logic [LW-1:0] BEAT_ELEMS = LW'(VW);

    typedef struct packed {
        phase_e        phase;
        logic          done;
        logic [AW-1:0] beat_addr;
        logic [AW-1:0] row_addr;
        logic [AW-1:0] step;
        logic [LW-1:0] rem;
        logic [LW-1:0] row_len;
        logic [LW-1:0] row_idx;
        logic [LW-1:0] rows;
        logic [LW-1:0] dec;
    } walk_t;

    walk_t s_q, s_d;

    logic [VW-1:0] mask_w;
    logic          row_last_w;
    logic [LW-1:0] next_len_w;
    logic [AW-1:0] next_addr_w;
    logic          final_row_w;
    logic          fire_w;
    logic          empty_cfg_w;

    isag_beat_fmt #(.VW(VW), .LW(LW)) u_fmt (
        .rem_i      (s_q.rem),
        .mask_o     (mask_w),
        .row_last_o (row_last_w)
    );

    isag_row_step #(.AW(AW), .LW(LW)) u_step (
        .row_len_i   (s_q.row_len),
        .dec_i       (s_q.dec),
        .row_idx_i   (s_q.row_idx),
        .rows_i      (s_q.rows),
        .row_addr_i  (s_q.row_addr),
        .step_i      (s_q.step),
        .next_len_o  (next_len_w),
        .next_addr_o (next_addr_w),
        .final_row_o (final_row_w)
    );

    assign fire_w      = (s_q.phase == PH_STREAM) && beat_ready_i;
    assign empty_cfg_w = (cfg_rows_i == '0) || (cfg_len_i == '0);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start_i) begin
                s_d.beat_addr = cfg_base_i;
                s_d.row_addr  = cfg_base_i;
                s_d.step      = cfg_stride_i + cfg_diag_i;
                s_d.rem       = cfg_len_i;
                s_d.row_len   = cfg_len_i;
                s_d.row_idx   = '0;
                s_d.rows      = cfg_rows_i;
                s_d.dec       = cfg_dec_i;
                if (empty_cfg_w) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.phase = PH_STREAM;
                end
            end
        end else if (fire_w) begin
            if (!row_last_w) begin
                s_d.beat_addr = s_q.beat_addr + BEAT_STEP;
                s_d.rem       = s_q.rem - BEAT_ELEMS;
            end else if (final_row_w) begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
            end else begin
                s_d.row_idx   = s_q.row_idx + 1'b1;
                s_d.row_len   = next_len_w;
                s_d.rem       = next_len_w;
                s_d.row_addr  = next_addr_w;
                s_d.beat_addr = next_addr_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign beat_valid_o     = (s_q.phase == PH_STREAM);
    assign beat_addr_o      = s_q.beat_addr;
    assign beat_mask_o      = mask_w;
    assign beat_row_last_o  = row_last_w;
    assign beat_strm_last_o = row_last_w && final_row_w;
    assign done_o           = s_q.done;

    // R7: an offered beat that is not taken stays put
    p_hold_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o)
            && $stable(beat_mask_o) && $stable(beat_row_last_o)
            && $stable(beat_strm_last_o));

    // R8: done follows the accepted final beat
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_ready_i && beat_strm_last_o |=> done_o && !beat_valid_o);

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: lane 0 is always live, and inner beats use every lane
    p_mask_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o |-> beat_mask_o[0] && (beat_row_last_o || (&beat_mask_o)));

    // R5: the stream's last beat also closes its row
    p_strm_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && beat_strm_last_o |-> beat_row_last_o);

    // R9: a start while streaming leaves the address alone when stalled
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !beat_ready_i && start_i |=> $stable(beat_addr_o));

endmodule

// File: tb/sim_isag_top.sv
module sim_isag_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int LW = 12;
    localparam int VW = 4;
    localparam int NVEC = 9;
    localparam int WATCHDOG = 20000;

    // base, rows, len, dec, stride, diag, stall, poke, expected beats
    localparam int VEC [0:NVEC-1][0:8] = '{
        '{'h0100, 4, 6, 1,    8, 0, 0, 0, 6},
        '{'h0000, 5, 5, 1,    5, 1, 1, 1, 6},
        '{'h0040, 2, 8, 0,   16, 0, 1, 0, 4},
        '{'h0200, 6, 5, 2,   10, 0, 0, 0, 4},
        '{'h0300, 1, 3, 0,    0, 0, 0, 0, 1},
        '{'h0010, 0, 5, 1,    4, 0, 0, 0, 0},
        '{'h0010, 3, 0, 0,    4, 0, 0, 0, 0},
        '{'hFFF0, 3, 7, 3, 'h20, 2, 1, 0, 4},
        '{'h0080, 2, 4, 4,    8, 0, 1, 0, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] cfg_base_i = '0;
    logic [LW-1:0] cfg_rows_i = '0;
    logic [LW-1:0] cfg_len_i = '0;
    logic [LW-1:0] cfg_dec_i = '0;
    logic [AW-1:0] cfg_stride_i = '0;
    logic [AW-1:0] cfg_diag_i = '0;
    logic          beat_ready_i = 1'b0;
    logic          beat_valid_o;
    logic [AW-1:0] beat_addr_o;
    logic [VW-1:0] beat_mask_o;
    logic          beat_row_last_o;
    logic          beat_strm_last_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isag_top #(.AW(AW), .LW(LW), .VW(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_base_i(cfg_base_i), .cfg_rows_i(cfg_rows_i), .cfg_len_i(cfg_len_i),
        .cfg_dec_i(cfg_dec_i), .cfg_stride_i(cfg_stride_i), .cfg_diag_i(cfg_diag_i),
        .beat_valid_o(beat_valid_o), .beat_ready_i(beat_ready_i),
        .beat_addr_o(beat_addr_o), .beat_mask_o(beat_mask_o),
        .beat_row_last_o(beat_row_last_o), .beat_strm_last_o(beat_strm_last_o),
        .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_vec(input int v);
        int base   = VEC[v][0];
        int rows   = VEC[v][1];
        int len    = VEC[v][2];
        int dec    = VEC[v][3];
        int stride = VEC[v][4];
        int diag   = VEC[v][5];
        int stall  = VEC[v][6];
        int poke   = VEC[v][7];
        int nbeats = 0;
        int cyc    = 0;
        @(negedge clk);
        cfg_base_i = AW'(base); cfg_rows_i = LW'(rows); cfg_len_i = LW'(len);
        cfg_dec_i = LW'(dec); cfg_stride_i = AW'(stride); cfg_diag_i = AW'(diag);
        start_i = 1'b1;
        beat_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < rows; i++) begin
            int rl = len - i * dec;
            if (rl <= 0) break;
            for (int j = 0; j < rl; j += VW) begin
                logic [AW-1:0] e_addr;
                logic [VW-1:0] e_mask;
                bit e_rl, e_sl;
                e_addr = AW'(base + i * (stride + diag) + j);
                for (int k = 0; k < VW; k++) e_mask[k] = (j + k < rl);
                e_rl = (j + VW >= rl);
                e_sl = e_rl && ((i + 1 == rows) || (len - (i + 1) * dec <= 0));
                while (1) begin
                    logic [AW-1:0] held;
                    beat_ready_i = !(stall != 0 && (cyc % 3) == 0);
                    cyc++;
                    if (poke != 0 && nbeats == 1) begin
                        start_i = 1'b1;
                        cfg_base_i = 16'h0AAA;
                        cfg_len_i = 12'd40;
                    end
                    if (!beat_ready_i) begin
                        held = beat_addr_o;
                        @(negedge clk);
                        start_i = 1'b0;
                        chk(beat_valid_o && beat_addr_o == held, "R7 hold",
                            int'(beat_addr_o), int'(held));
                        continue;
                    end
                    chk(beat_valid_o, "R2 valid", int'(beat_valid_o), 1);
                    chk(beat_addr_o == e_addr, "R3 address", int'(beat_addr_o), int'(e_addr));
                    chk(beat_mask_o == e_mask, "R4 mask", int'(beat_mask_o), int'(e_mask));
                    chk(beat_row_last_o == e_rl, "R5 row last", int'(beat_row_last_o), int'(e_rl));
                    chk(beat_strm_last_o == e_sl, "R5 stream last",
                        int'(beat_strm_last_o), int'(e_sl));
                    nbeats++;
                    @(negedge clk);
                    start_i = 1'b0;
                    break;
                end
            end
        end
        beat_ready_i = 1'b0;
        chk(done_o == 1'b1 && !beat_valid_o, "R8 done pulse", int'(done_o), 1);
        chk(nbeats == VEC[v][8], (dec == 0) ? "R6 beat count" : "R2 beat count",
            nbeats, VEC[v][8]);
        if (poke != 0) chk(nbeats == VEC[v][8], "R9 stray start", nbeats, VEC[v][8]);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 single cycle", int'(done_o), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!beat_valid_o && !done_o, "R1 reset", int'({beat_valid_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid_o && !done_o, "R1 after reset", int'({beat_valid_o, done_o}), 0);

        for (int v = 0; v < NVEC; v++) run_vec(v);

        // R1: reset in mid-stream drops the beat
        cfg_base_i = 16'h0500; cfg_rows_i = 12'd4; cfg_len_i = 12'd9;
        cfg_dec_i = 12'd1; cfg_stride_i = 16'd9; cfg_diag_i = 16'd0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(beat_valid_o && beat_addr_o == 16'h0500, "R3 first beat", int'(beat_addr_o), 'h500);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!beat_valid_o && !done_o, "R1 mid-stream reset", int'({beat_valid_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid_o, "R1 stays idle", int'(beat_valid_o), 0);

        // R8: run after a reset still completes normally
        run_vec(0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule